// File: doc/BRIEF.md
# Two-Socket PC Card Cycle Sequencer

This block turns single host requests into the control strobe sequences that two PC card sockets (A and B) expect. The host presents a socket select, the low address bit, a byte/word size flag, a direction flag, a memory/I/O flag and an attribute/common flag. The block then runs a fixed phase sequence and drives the per-socket low- and high-byte card enables, the register select line, the data buffer direction, and the memory output and write enables. The host sees a one-clock completion pulse at the end.

The card status inputs are read according to each socket's mode. In memory mode, the ready pin gates the start of a transfer, and the write-protect pin refuses writes. In I/O mode, socket A's ready pin becomes an interrupt request, and the two write-protect pins are ORed into a 16-bit port indication. Each socket has a mode configuration input and an active-high card reset output. While card reset is active, that socket is treated as a memory card. Card reset is forced on for a short time after system reset. A static programming-voltage enable is registered per socket.

The sequencer states are IDLE, SETUP, STROBE, HOLD and DENY. The transitions are:
- IDLE to SETUP when a request is accepted.
- IDLE to DENY when an accepted request is a protected memory write.
- SETUP to STROBE always.
- STROBE to HOLD when the minimum strobe time has passed and no wait is requested.
- HOLD to SETUP when the split second beat is still pending, otherwise HOLD to IDLE.
- DENY to IDLE always.

Top module: `pccard_ctrl`

## Requirements
- R1: Whenever no cycle is in progress (IDLE), both sockets' byte enables, `oe_n`, `we_n` and `reg_sel_n` are high, and `dir_out`, `xfer_done` and `xfer_denied` are low.
- R2: An accepted cycle spends exactly one clock in SETUP, at least STROBE_MIN (default 2) clocks in STROBE and one clock in HOLD. `xfer_done` is high for exactly the single HOLD clock of the last beat.
- R3: STROBE is extended for every clock in which either `wait_n[0]` or `wait_n[1]` is low (the two lines are ANDed).
- R4: Byte enables assert (low) only for the addressed socket (`req_sock` 0 = A = bit 0, 1 = B = bit 1). A byte access to an even address (`req_odd`=0) asserts only `ce_lo_n`, and one to an odd address asserts only `ce_hi_n`. A word request to an odd address is handled as an odd byte access.
- R5: A word request (`req_wide`=1) to an even address asserts both enables in a single beat when the target is 16-bit capable. A memory-mode socket is always capable, and an I/O-mode socket is capable when `wp[0] | wp[1]` is high.
- R6: A word request to an even address on a target that is not capable runs two full SETUP/STROBE/HOLD beats: the even byte (`ce_lo_n`) first, then the odd byte (`ce_hi_n`). `xfer_done` fires only in the second HOLD.
- R7: During a cycle, `reg_sel_n` is high for common memory and low for attribute memory (`req_attr`=1) and for every I/O access.
- R8: During a cycle, `dir_out` is high for writes (`req_write`=1) and low for reads.
- R9: `oe_n` is low only in STROBE of a memory read, and `we_n` is low only in STROBE of a memory write. Neither asserts for I/O accesses.
- R10: A memory-mode write to a socket whose `wp` bit is high drives no enables or strobes. It enters DENY for one clock, with `xfer_done` and `xfer_denied` high. In I/O mode, `wp` does not block writes.
- R11: A request to a memory-mode socket whose `rdy` bit is low waits in IDLE until it is high. I/O-mode sockets ignore `rdy`. `irq_a` equals `rdy[0]` while socket A is in I/O mode, and is 0 otherwise.
- R12: `card_rst` is 2'b11 for the first POR_CLKS (default 8) clocks after reset, and afterwards equals `card_rst_req`. A socket under card reset behaves as a memory-mode socket whatever `cfg_io` says.
- R13: `vpp_en` takes the value of `vpp_req` one clock later and is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present (accepted in IDLE) |
| req_sock | input | 1 | Target socket, 0 = A, 1 = B |
| req_odd | input | 1 | Address bit 0 |
| req_wide | input | 1 | Word (16-bit) request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | Unused by socket mode decode; host I/O flag, must match socket mode |
| req_attr | input | 1 | Attribute memory select |
| cfg_io | input | 2 | Per-socket I/O mode configuration |
| card_rst_req | input | 2 | Per-socket card reset request |
| vpp_req | input | 2 | Per-socket programming-voltage enable request |
| wait_n | input | 2 | Per-socket wait, active low |
| rdy | input | 2 | Per-socket ready / interrupt request |
| wp | input | 2 | Per-socket write protect / 16-bit port |
| ce_lo_n | output | 2 | Low-byte card enables, active low |
| ce_hi_n | output | 2 | High-byte card enables, active low |
| reg_sel_n | output | 1 | Register select, low for attribute or I/O |
| dir_out | output | 1 | Buffer direction, high = host to card |
| oe_n | output | 1 | Card memory output enable, active low |
| we_n | output | 1 | Card memory write enable, active low |
| xfer_done | output | 1 | One-clock completion pulse |
| xfer_denied | output | 1 | Completion was a refused protected write |
| irq_a | output | 1 | Socket A interrupt request |
| card_rst | output | 2 | Per-socket card reset, active high |
| vpp_en | output | 2 | Per-socket programming-voltage enable |

## Verification
The main sequence is swept over every combination of socket, direction, mode, memory space, address parity, size and capability pattern. The capability pattern is the other socket's write-protect pin, which shows the OR. Each sweep point also uses a different count of wait clocks on alternating wait lines. Comparing every clock's output vector tells apart lane selection (even, odd, both, split order), the register-select and strobe decode per mode, and the strobe length under waits on either line. Directed runs separate the blocking cases from the ordinary ones: a protected memory write against a protected read or I/O write, a memory socket that is not ready against an I/O socket that is not ready, and an I/O configuration under card reset against a plain one.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DENY
    } pcc_state_e;

    typedef struct packed {
        logic sock;
        logic write;
        logic io;
        logic attr;
        logic lane_lo;
        logic lane_hi;
        logic split;
    } pcc_xfer_t;

endpackage

// File: rtl/pcc_por.sv
module pcc_por #(
    parameter int POR_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic active
);
    localparam int CW = $clog2(POR_CLKS + 1);
    localparam logic [CW-1:0] CNT_END = CW'(POR_CLKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CNT_END)
            cnt <= cnt + 1'b1;
    end

    assign active = (cnt != CNT_END);
endmodule

// File: rtl/pcc_status.sv
module pcc_status #(
    parameter int NSOCK = 2
) (
    input  logic [NSOCK-1:0] cfg_io,
    input  logic [NSOCK-1:0] card_rst,
    input  logic [NSOCK-1:0] wait_n,
    input  logic [NSOCK-1:0] rdy,
    input  logic [NSOCK-1:0] wp,
    output logic [NSOCK-1:0] eff_io,
    output logic [NSOCK-1:0] ready_ok,
    output logic [NSOCK-1:0] wp_block,
    output logic [NSOCK-1:0] wide_cap,
    output logic             wait_ok,
    output logic             irq_a
);
    logic io16;

    assign io16    = |wp;
    assign wait_ok = &wait_n;

    for (genvar g = 0; g < NSOCK; g++) begin : g_sock
        // card reset forces memory-only interpretation
        assign eff_io[g]   = cfg_io[g] & ~card_rst[g];
        assign ready_ok[g] = eff_io[g] | rdy[g];
        assign wp_block[g] = ~eff_io[g] & wp[g];
        assign wide_cap[g] = ~eff_io[g] | io16;
    end

    assign irq_a = eff_io[0] & rdy[0];
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
    import pcc_pkg::*;
#(
    parameter int STROBE_MIN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_sock,
    input  logic       req_odd,
    input  logic       req_wide,
    input  logic       req_write,
    input  logic       req_attr,
    input  logic [1:0] eff_io,
    input  logic [1:0] ready_ok,
    input  logic [1:0] wp_block,
    input  logic [1:0] wide_cap,
    input  logic       wait_ok,
    output logic [1:0] ce_lo_n,
    output logic [1:0] ce_hi_n,
    output logic       reg_sel_n,
    output logic       dir_out,
    output logic       oe_n,
    output logic       we_n,
    output logic       xfer_done,
    output logic       xfer_denied
);
    localparam int SCW = $clog2(STROBE_MIN + 1);
    localparam logic [SCW-1:0] SC_LAST = SCW'(STROBE_MIN - 1);

    pcc_state_e state, state_nx;
    pcc_xfer_t  cur;
    logic [SCW-1:0] scnt;
    logic accept, wide_even;

    assign accept    = (state == ST_IDLE) && req_valid && ready_ok[req_sock];
    assign wide_even = req_wide && !req_odd;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = (req_write && wp_block[req_sock]) ? ST_DENY : ST_SETUP;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: if (scnt >= SC_LAST && wait_ok) state_nx = ST_HOLD;
            ST_HOLD:   state_nx = cur.split ? ST_SETUP : ST_IDLE;
            ST_DENY:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            scnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_STROBE) begin
                if (scnt < SC_LAST) scnt <= scnt + 1'b1;
            end else begin
                scnt <= '0;
            end
            if (accept) begin
                cur.sock    <= req_sock;
                cur.write   <= req_write;
                cur.io      <= eff_io[req_sock];
                cur.attr    <= req_attr;
                cur.lane_lo <= !req_odd;
                cur.lane_hi <= req_odd || (wide_even && wide_cap[req_sock]);
                cur.split   <= wide_even && !wide_cap[req_sock];
            end else if (state == ST_HOLD && cur.split) begin
                cur.lane_lo <= 1'b0;
                cur.lane_hi <= 1'b1;
                cur.split   <= 1'b0;
            end
        end
    end

    always_comb begin
        ce_lo_n     = 2'b11;
        ce_hi_n     = 2'b11;
        reg_sel_n   = 1'b1;
        dir_out     = 1'b0;
        oe_n        = 1'b1;
        we_n        = 1'b1;
        xfer_done   = 1'b0;
        xfer_denied = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                ce_lo_n[cur.sock] = !cur.lane_lo;
                ce_hi_n[cur.sock] = !cur.lane_hi;
                reg_sel_n = !(cur.attr || cur.io);
                dir_out   = cur.write;
                if (state == ST_STROBE && !cur.io) begin
                    oe_n = cur.write;
                    we_n = !cur.write;
                end
                xfer_done = (state == ST_HOLD) && !cur.split;
            end
            ST_DENY: begin
                xfer_done   = 1'b1;
                xfer_denied = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pccard_ctrl.sv
module pccard_ctrl #(
    parameter int STROBE_MIN = 2,
    parameter int POR_CLKS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_sock,
    input  logic       req_odd,
    input  logic       req_wide,
    input  logic       req_write,
    input  logic       req_io,
    input  logic       req_attr,
    input  logic [1:0] cfg_io,
    input  logic [1:0] card_rst_req,
    input  logic [1:0] vpp_req,
    input  logic [1:0] wait_n,
    input  logic [1:0] rdy,
    input  logic [1:0] wp,
    output logic [1:0] ce_lo_n,
    output logic [1:0] ce_hi_n,
    output logic       reg_sel_n,
    output logic       dir_out,
    output logic       oe_n,
    output logic       we_n,
    output logic       xfer_done,
    output logic       xfer_denied,
    output logic       irq_a,
    output logic [1:0] card_rst,
    output logic [1:0] vpp_en
);
    logic       por_active;
    logic [1:0] eff_io, ready_ok, wp_block, wide_cap;
    logic       wait_ok;
    logic       io_flag_unused;

    // the socket's configured mode decides the cycle type; host flag is informational
    assign io_flag_unused = req_io;

    pcc_por #(.POR_CLKS(POR_CLKS)) u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (por_active)
    );

    assign card_rst = {2{por_active}} | card_rst_req;

    pcc_status #(.NSOCK(2)) u_status (
        .cfg_io   (cfg_io),
        .card_rst (card_rst),
        .wait_n   (wait_n),
        .rdy      (rdy),
        .wp       (wp),
        .eff_io   (eff_io),
        .ready_ok (ready_ok),
        .wp_block (wp_block),
        .wide_cap (wide_cap),
        .wait_ok  (wait_ok),
        .irq_a    (irq_a)
    );

    pcc_fsm #(.STROBE_MIN(STROBE_MIN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_sock    (req_sock),
        .req_odd     (req_odd),
        .req_wide    (req_wide),
        .req_write   (req_write),
        .req_attr    (req_attr),
        .eff_io      (eff_io),
        .ready_ok    (ready_ok),
        .wp_block    (wp_block),
        .wide_cap    (wide_cap),
        .wait_ok     (wait_ok),
        .ce_lo_n     (ce_lo_n),
        .ce_hi_n     (ce_hi_n),
        .reg_sel_n   (reg_sel_n),
        .dir_out     (dir_out),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .xfer_done   (xfer_done),
        .xfer_denied (xfer_denied)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) vpp_en <= 2'b00;
        else        vpp_en <= vpp_req;
    end
endmodule

// File: rtl/pccard_ctrl_chk.sv
module pccard_ctrl_chk #(
    parameter int POR_CLKS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ce_lo_n,
    input logic [1:0] ce_hi_n,
    input logic       dir_out,
    input logic       oe_n,
    input logic       we_n,
    input logic       xfer_done,
    input logic       xfer_denied,
    input logic [1:0] card_rst
);
    localparam int CW = $clog2(POR_CLKS + 1);
    localparam logic [CW-1:0] CNT_END = CW'(POR_CLKS);
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != CNT_END) since_rst <= since_rst + 1'b1;
    end

    AST_ONE_SOCKET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n[0] & ce_hi_n[0]) | (ce_lo_n[1] & ce_hi_n[1])); // R4
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n | we_n); // R9
    AST_OE_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dir_out); // R8
    AST_WE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dir_out); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R2
    AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |=> !oe_n); // R2
    AST_DENY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_denied |-> (ce_lo_n == 2'b11 && ce_hi_n == 2'b11 && oe_n && we_n && xfer_done)); // R10
    AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != CNT_END) |-> (card_rst == 2'b11)); // R12
endmodule

bind pccard_ctrl pccard_ctrl_chk #(.POR_CLKS(POR_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_lo_n     (ce_lo_n),
    .ce_hi_n     (ce_hi_n),
    .dir_out     (dir_out),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .xfer_done   (xfer_done),
    .xfer_denied (xfer_denied),
    .card_rst    (card_rst)
);

// File: tb/pccard_ctrl_tb.sv
`timescale 1ns/1ps
module pccard_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_sock = 0, req_odd = 0, req_wide = 0;
    logic req_write = 0, req_io = 0, req_attr = 0;
    logic [1:0] cfg_io = 0, card_rst_req = 0, vpp_req = 0;
    logic [1:0] wait_n = 2'b11, rdy = 2'b11, wp = 2'b00;
    logic [1:0] ce_lo_n, ce_hi_n, card_rst, vpp_en;
    logic reg_sel_n, dir_out, oe_n, we_n, xfer_done, xfer_denied, irq_a;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pccard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sock(req_sock),
        .req_odd(req_odd), .req_wide(req_wide), .req_write(req_write),
        .req_io(req_io), .req_attr(req_attr), .cfg_io(cfg_io),
        .card_rst_req(card_rst_req), .vpp_req(vpp_req), .wait_n(wait_n),
        .rdy(rdy), .wp(wp), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .reg_sel_n(reg_sel_n), .dir_out(dir_out), .oe_n(oe_n), .we_n(we_n),
        .xfer_done(xfer_done), .xfer_denied(xfer_denied), .irq_a(irq_a),
        .card_rst(card_rst), .vpp_en(vpp_en)
    );

    function automatic logic [9:0] act_vec();
        return {ce_lo_n, ce_hi_n, reg_sel_n, dir_out, oe_n, we_n, xfer_done, xfer_denied};
    endfunction

    // ph: 0 idle, 1 setup, 2 strobe, 3 hold, 4 deny
    function automatic logic [9:0] exp_vec(int ph, bit s, bit lo, bit hi, bit attr,
                                           bit eio, bit wr, bit last);
        logic [1:0] lo_n = 2'b11, hi_n = 2'b11;
        logic rs = 1, d = 0, o = 1, w = 1, dn = 0, dd = 0;
        if (ph >= 1 && ph <= 3) begin
            lo_n[s] = !lo; hi_n[s] = !hi;
            rs = !(attr || eio); d = wr;
            if (ph == 2 && !eio) begin o = wr; w = !wr; end
            dn = (ph == 3) && last;
        end else if (ph == 4) begin
            dn = 1; dd = 1;
        end
        return {lo_n, hi_n, rs, d, o, w, dn, dd};
    endfunction

    task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk2(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic xfer(bit s, bit wr, bit cio, bit rreq, bit attr, bit odd, bit wide,
                        logic [1:0] wpv, int w);
        bit eio = cio && !rreq;
        bit cap = eio ? (wpv != 2'b00) : 1'b1;
        bit deny = !eio && wr && wpv[s];
        int nb;
        bit lo0, hi0;
        cfg_io = {cio, cio}; card_rst_req = {rreq, rreq}; wp = wpv; rdy = 2'b11;
        wait_n = 2'b11;
        req_sock = s; req_write = wr; req_io = eio; req_attr = attr;
        req_odd = odd; req_wide = wide; req_valid = 1;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        if (deny) begin
            chk("R10 deny", act_vec(), exp_vec(4, s, 0, 0, attr, eio, wr, 1));
            @(negedge clk);
            chk("R1 idle after deny", act_vec(), exp_vec(0, s, 0, 0, attr, eio, wr, 0));
            return;
        end
        nb = (wide && !odd && !cap) ? 2 : 1;
        lo0 = !odd;
        hi0 = odd || (wide && !odd && cap);
        for (int b = 0; b < nb; b++) begin
            bit lo = (b == 0) ? lo0 : 1'b0;
            bit hi = (b == 0) ? hi0 : 1'b1;
            bit last = (b == nb - 1);
            chk("R4 R5 R6 R7 R8 setup", act_vec(), exp_vec(1, s, lo, hi, attr, eio, wr, last));
            @(negedge clk);
            for (int i = 0; i < w + 2; i++) begin
                chk("R2 R3 R9 strobe", act_vec(), exp_vec(2, s, lo, hi, attr, eio, wr, last));
                wait_n = (i >= 1 && i <= w) ? ((i % 2) ? 2'b10 : 2'b01) : 2'b11;
                @(negedge clk);
            end
            wait_n = 2'b11;
            chk("R2 R6 hold", act_vec(), exp_vec(3, s, lo, hi, attr, eio, wr, last));
            @(negedge clk);
        end
        chk("R1 idle after cycle", act_vec(), exp_vec(0, s, 0, 0, attr, eio, wr, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", act_vec(), exp_vec(0, 0, 0, 0, 0, 0, 0, 0));
        chk2("R12 reset card_rst", card_rst, 2'b11);
        chk2("R13 reset vpp", vpp_en, 2'b00);
        rst_n = 1;
        chk2("R12 por start", card_rst, 2'b11);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            chk2("R12 por window", card_rst, (k < 8) ? 2'b11 : 2'b00);
        end

        // R13 vpp passthrough
        vpp_req = 2'b10; @(negedge clk);
        chk2("R13 vpp", vpp_en, 2'b10);
        vpp_req = 2'b01; #1;
        chk2("R13 vpp not yet", vpp_en, 2'b10);
        @(negedge clk);
        chk2("R13 vpp follow", vpp_en, 2'b01);

        // main sweep
        for (int idx = 0; idx < 128; idx++) begin
            bit s = idx[0], wr = idx[1], cio = idx[2], attr = idx[3];
            bit odd = idx[4], wide = idx[5], capb = idx[6];
            logic [1:0] wpv = 2'b00;
            if (cio && capb) wpv = s ? 2'b01 : 2'b10;
            xfer(s, wr, cio, 0, attr, odd, wide, wpv, idx % 3);
        end

        // R10 protected memory write, protected read allowed, I/O write not blocked
        xfer(0, 1, 0, 0, 0, 0, 0, 2'b01, 0);
        xfer(1, 1, 0, 0, 1, 1, 0, 2'b10, 0);
        xfer(1, 0, 0, 0, 0, 0, 1, 2'b10, 1);
        xfer(0, 1, 1, 0, 0, 0, 1, 2'b01, 0);
        xfer(0, 1, 0, 0, 0, 0, 0, 2'b10, 0);

        // R12 card reset forces memory mode even with I/O configured
        xfer(1, 0, 1, 1, 0, 0, 1, 2'b11, 0);
        xfer(0, 1, 1, 1, 0, 1, 0, 2'b00, 2);
        card_rst_req = 2'b10; #1;
        chk2("R12 card_rst follows request", card_rst, 2'b10);
        card_rst_req = 2'b00;

        // R11 ready gating in memory mode
        cfg_io = 2'b00; wp = 2'b00; rdy = 2'b10;
        req_sock = 0; req_write = 0; req_attr = 0; req_odd = 0; req_wide = 0;
        req_valid = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 not ready waits", act_vec(), exp_vec(0, 0, 0, 0, 0, 0, 0, 0));
        end
        rdy = 2'b11;
        @(negedge clk);
        req_valid = 0;
        chk("R11 starts when ready", act_vec(), exp_vec(1, 0, 1, 0, 0, 0, 0, 1));
        repeat (4) @(negedge clk);
        chk("R1 idle after ready run", act_vec(), exp_vec(0, 0, 0, 0, 0, 0, 0, 0));

        // R11 I/O mode ignores ready
        cfg_io = 2'b10; rdy = 2'b00;
        req_sock = 1; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R11 io ignores rdy", act_vec(), exp_vec(1, 1, 1, 0, 0, 1, 0, 1));
        repeat (4) @(negedge clk);
        chk("R1 idle after io run", act_vec(), exp_vec(0, 0, 0, 0, 0, 0, 0, 0));

        // R11 interrupt reporting
        cfg_io = 2'b01; rdy = 2'b01; #1;
        chk2("R11 irq io mode", {1'b0, irq_a}, 2'b01);
        rdy = 2'b10; #1;
        chk2("R11 irq follows rdy A", {1'b0, irq_a}, 2'b00);
        cfg_io = 2'b00; rdy = 2'b01; #1;
        chk2("R11 irq memory mode", {1'b0, irq_a}, 2'b00);
        cfg_io = 2'b01; card_rst_req = 2'b01; #1;
        chk2("R11 R12 irq under card reset", {1'b0, irq_a}, 2'b00);
        card_rst_req = 2'b00;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule